// File: doc/BRIEF.md
# Shadow Register Load Controller

This block holds the timing settings of a trigger-delay peripheral in double-buffered form. These settings are the count modulus, the interrupt delay, one delay per pre-trigger of every channel, and one delay per pulse output. Software writes any of them into a shadow buffer through a small select/data write port. The timing logic always sees a separate set of active registers. Buffer writes never reach the active registers directly. All buffers are copied into the active set together, in a single clock edge.

Software arms the copy by writing 1 to the load-arm input while the peripheral is enabled. A two-bit load mode then chooses when the copy happens. It can happen at once, at the next counter/modulus match, at the next detected trigger, or at whichever of those two events arrives first. The pending output stays high from the arm until the copy takes place, so software can poll it before it rewrites the buffers.

Top module: `shadow_load_ctrl`

## Requirements
- R1: After reset, every active register reads 0 and `loadPending` is 0.
- R2: When `armWr` is 1 at a clock edge and `enable` is 1, `loadPending` reads 1 after that edge. When `enable` is 0, an `armWr` pulse leaves `loadPending` at 0 and changes no active register.
- R3: Load mode 2'b00 copies the buffers at the first clock edge after the one that registered the arm. `loadPending` is high for exactly one cycle and drops at the same edge as the copy.
- R4: Load mode 2'b01 keeps the transfer pending while `modMatch` is 0, whatever `trigEvent` does. It copies at the first edge where `modMatch` is 1.
- R5: Load mode 2'b10 keeps the transfer pending while `trigEvent` is 0, whatever `modMatch` does. It copies at the first edge where `trigEvent` is 1.
- R6: Load mode 2'b11 copies at the first edge where `modMatch` or `trigEvent` is 1.
- R7: Buffer writes made with no transfer pending leave every active register unchanged.
- R8: Every buffer write made before the copy edge is carried into the active set, including a write presented in the same cycle as the copy.
- R9: Write select map: 0 is the modulus, 1 is the interrupt delay, and 2 + ch*NUM_PRE + pt is the delay of pre-trigger pt of channel ch. The NUM_PO pulse-out delays follow in order. Select codes at or above the register count write nothing.
- R10: When `enable` is 0 at a clock edge, a pending transfer is dropped without copying, and `loadPending` reads 0 after that edge.
- R11: `modMatch` and `trigEvent` pulses with no transfer pending cause no copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Peripheral enable |
| wrEn | input | 1 | Buffer write strobe |
| wrSel | input | SEL_W (4) | Buffer select, see R9 |
| wrData | input | DATA_W (16) | Buffer write data |
| armWr | input | 1 | Write of 1 to the load-arm bit |
| loadMode | input | 2 | Transfer moment select |
| modMatch | input | 1 | Counter equals modulus event |
| trigEvent | input | 1 | Trigger input detected event |
| loadPending | output | 1 | Load-arm readback, high while a transfer waits |
| activeMod | output | DATA_W | Active modulus |
| activeIdly | output | DATA_W | Active interrupt delay |
| activeChDly | output | NUM_CH*NUM_PRE*DATA_W | Active channel delays, index ch*NUM_PRE+pt |
| activePoDly | output | NUM_PO*DATA_W | Active pulse-out delays |

## Verification
A fault in the pending flag shows up in `loadPending` one cycle later. Because the flag gates the copy, the same fault also appears as an early, missing or repeated update of the active outputs on the next qualifying event. A fault in a shadow buffer stays hidden until the next copy. Every copy therefore compares all active outputs against a model of the buffers, and random writes and events keep copies happening every few dozen cycles.

// File: rtl/shadow_load_pkg.sv
package shadow_load_pkg;

  typedef enum logic [1:0] {
    LOAD_NOW      = 2'b00,
    LOAD_AT_MATCH = 2'b01,
    LOAD_AT_TRIG  = 2'b10,
    LOAD_AT_FIRST = 2'b11
  } loadMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic bufWrite;  // write select is in range
    logic load;      // copy all buffers into the active set this edge
  } ldStrobe_t;

endpackage

// File: rtl/shadow_load_ctl.sv
module shadow_load_ctl
  import shadow_load_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             armWr,
  input  logic [1:0]       loadMode,
  input  logic             modMatch,
  input  logic             trigEvent,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  output ldStrobe_t        strobe,
  output logic             pending
);

  localparam logic [SEL_W:0] REG_LIMIT = (SEL_W + 1)'(NREG);

  loadMode_e mode;
  logic      eventHit;

  assign mode = loadMode_e'(loadMode);

  always_comb begin
    case (mode)
      LOAD_NOW:      eventHit = 1'b1;
      LOAD_AT_MATCH: eventHit = modMatch;
      LOAD_AT_TRIG:  eventHit = trigEvent;
      default:       eventHit = modMatch | trigEvent;
    endcase
  end

  assign strobe.load     = pending & enable & eventHit;
  assign strobe.bufWrite = wrEn & ({1'b0, wrSel} < REG_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pending <= 1'b0;
    else if (!enable) pending <= 1'b0;
    else              pending <= (pending & ~strobe.load) | armWr;
  end

  assert_arm_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    !pending && !(armWr && enable) |=> !pending);

  assert_now_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    pending && enable && loadMode == 2'b00 && !armWr |=> !pending);

  assert_match_waits_R4: assert property (@(posedge clk) disable iff (!rstN)
    pending && enable && loadMode == 2'b01 && !modMatch |=> pending);

  assert_trig_waits_R5: assert property (@(posedge clk) disable iff (!rstN)
    pending && enable && loadMode == 2'b10 && !trigEvent |=> pending);

  assert_first_waits_R6: assert property (@(posedge clk) disable iff (!rstN)
    pending && enable && loadMode == 2'b11 && !modMatch && !trigEvent |=> pending);

  assert_disable_cancels_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pending);

endmodule

// File: rtl/shadow_load_dp.sv
module shadow_load_dp
  import shadow_load_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int SEL_W  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ldStrobe_t              strobe,
  input  logic [SEL_W-1:0]       wrSel,
  input  logic [DATA_W-1:0]      wrData,
  output logic [NREG*DATA_W-1:0] activeAll
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] bufQ;
    logic [DATA_W-1:0] bufD;
    logic [DATA_W-1:0] actQ;
    logic              hit;

    assign hit  = strobe.bufWrite && (wrSel == SEL_W'(i));
    // same-cycle write is forwarded into the copy
    assign bufD = hit ? wrData : bufQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufQ <= '0;
        actQ <= '0;
      end else begin
        bufQ <= bufD;
        if (strobe.load) actQ <= bufD;
      end
    end

    assign activeAll[i*DATA_W +: DATA_W] = actQ;
  end

  assert_hold_without_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(activeAll));

endmodule

// File: rtl/shadow_load_ctrl.sv
module shadow_load_ctrl
  import shadow_load_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_CH  = 2,
  parameter int NUM_PRE = 2,
  parameter int NUM_PO  = 2,
  localparam int NDLY   = NUM_CH * NUM_PRE,
  localparam int NREG   = 2 + NDLY + NUM_PO,
  localparam int SEL_W  = $clog2(NREG) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enable,
  input  logic                     wrEn,
  input  logic [SEL_W-1:0]         wrSel,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     armWr,
  input  logic [1:0]               loadMode,
  input  logic                     modMatch,
  input  logic                     trigEvent,
  output logic                     loadPending,
  output logic [DATA_W-1:0]        activeMod,
  output logic [DATA_W-1:0]        activeIdly,
  output logic [NDLY*DATA_W-1:0]   activeChDly,
  output logic [NUM_PO*DATA_W-1:0] activePoDly
);

  ldStrobe_t               strobe;
  logic [NREG*DATA_W-1:0]  activeAll;

  shadow_load_ctl #(.NREG(NREG), .SEL_W(SEL_W)) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .armWr(armWr),
    .loadMode(loadMode), .modMatch(modMatch), .trigEvent(trigEvent),
    .wrEn(wrEn), .wrSel(wrSel), .strobe(strobe), .pending(loadPending)
  );

  shadow_load_dp #(.DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrSel(wrSel),
    .wrData(wrData), .activeAll(activeAll)
  );

  assign activeMod   = activeAll[0 +: DATA_W];
  assign activeIdly  = activeAll[DATA_W +: DATA_W];
  assign activeChDly = activeAll[2*DATA_W +: NDLY*DATA_W];
  assign activePoDly = activeAll[(2+NDLY)*DATA_W +: NUM_PO*DATA_W];

endmodule

// File: tb/shadow_load_ctrl_test.sv
module shadow_load_ctrl_test;

  localparam int NREG = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrSel = '0;
  logic [15:0] wrData = '0;
  logic        armWr = 1'b0;
  logic [1:0]  loadMode = '0;
  logic        modMatch = 1'b0;
  logic        trigEvent = 1'b0;
  logic        loadPending;
  logic [15:0] activeMod, activeIdly;
  logic [63:0] activeChDly;
  logic [31:0] activePoDly;

  int checks = 0;
  int errors = 0;
  logic [15:0] expBuf [NREG];
  logic [15:0] expAct [NREG];
  logic        expPend = 1'b0;

  always #5 clk = ~clk;

  shadow_load_ctrl uut (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .armWr(armWr), .loadMode(loadMode), .modMatch(modMatch),
    .trigEvent(trigEvent), .loadPending(loadPending), .activeMod(activeMod),
    .activeIdly(activeIdly), .activeChDly(activeChDly), .activePoDly(activePoDly)
  );

  function automatic logic [15:0] dutAct(int i);
    if (i == 0) return activeMod;
    if (i == 1) return activeIdly;
    if (i < 6)  return activeChDly[(i-2)*16 +: 16];
    return activePoDly[(i-6)*16 +: 16];
  endfunction

  function automatic bit eventFor(logic [1:0] m, logic mm, logic tr);
    case (m)
      2'b00:   return 1'b1;
      2'b01:   return mm;
      2'b10:   return tr;
      default: return mm | tr;
    endcase
  endfunction

  task automatic modelEdge();
    bit fire;
    fire = expPend && enable && eventFor(loadMode, modMatch, trigEvent);
    if (wrEn && wrSel < NREG) expBuf[wrSel] = wrData;
    if (fire) for (int i = 0; i < NREG; i++) expAct[i] = expBuf[i];
    if (!enable) expPend = 1'b0;
    else         expPend = (expPend && !fire) || armWr;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    bit bad = 0;
    checks++;
    if (loadPending !== expPend) begin
      bad = 1;
      $display("FAIL %s pending: actual %b expected %b", tag, loadPending, expPend);
    end
    for (int i = 0; i < NREG; i++)
      if (dutAct(i) !== expAct[i]) begin
        bad = 1;
        $display("FAIL %s reg %0d: actual %h expected %h", tag, i, dutAct(i), expAct[i]);
      end
    if (bad) errors++;
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic idle();
    wrEn = 0; armWr = 0; modMatch = 0; trigEvent = 0;
  endtask

  task automatic writeBuf(string tag, int sel, logic [15:0] d);
    wrEn = 1; wrSel = 4'(sel); wrData = d;
    cyc(tag);
    wrEn = 0;
  endtask

  task automatic arm(string tag);
    armWr = 1;
    cyc(tag);
    armWr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) begin expBuf[i] = 0; expAct[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    compareAll("R1");
    rstN = 1;
    enable = 1;
    cyc("R1");

    // R9 map: distinct values, immediate load
    loadMode = 2'b00;
    for (int i = 0; i < NREG; i++) writeBuf("R9", i, 16'h1100 + 16'(i*17));
    arm("R9");
    cyc("R9");
    chk("R9 modulus", {16'h0, activeMod}, 32'h1100);
    chk("R9 idly", {16'h0, activeIdly}, 32'h1111);
    chk("R9 ch1 pt0", {16'h0, activeChDly[32 +: 16]}, 32'h1144);
    chk("R9 po1", {16'h0, activePoDly[16 +: 16]}, 32'h1177);
    // out-of-range selects write nothing
    for (int s = NREG; s < 16; s++) writeBuf("R9", s, 16'hDEAD);
    arm("R9");
    cyc("R9");
    chk("R9 range modulus", {16'h0, activeMod}, 32'h1100);

    // R7: writes with nothing pending do not reach the active set
    writeBuf("R7", 0, 16'h0BAD);
    repeat (3) cyc("R7");
    chk("R7 hold", {16'h0, activeMod}, 32'h1100);

    // R2: arm ignored while disabled
    enable = 0;
    arm("R2");
    chk("R2 disabled arm", {31'h0, loadPending}, 32'h0);
    repeat (2) cyc("R2");
    chk("R2 no copy", {16'h0, activeMod}, 32'h1100);
    enable = 1;

    // R3: one-cycle pending, copy on following edge
    arm("R3");
    chk("R3 pending high", {31'h0, loadPending}, 32'h1);
    cyc("R3");
    chk("R3 pending low", {31'h0, loadPending}, 32'h0);
    chk("R3 copied", {16'h0, activeMod}, 32'h0BAD);

    // R4: modulus match only
    loadMode = 2'b01;
    writeBuf("R4", 1, 16'h4444);
    arm("R4");
    trigEvent = 1; cyc("R4"); trigEvent = 0;
    repeat (3) cyc("R4");
    chk("R4 still pending", {31'h0, loadPending}, 32'h1);
    // R8: write while pending and write in the copy cycle
    writeBuf("R8", 2, 16'h8282);
    modMatch = 1; wrEn = 1; wrSel = 4'd3; wrData = 16'h8383;
    cyc("R4");
    idle();
    chk("R4 copied", {16'h0, activeIdly}, 32'h4444);
    chk("R8 pending write", {16'h0, activeChDly[0 +: 16]}, 32'h8282);
    chk("R8 same-cycle write", {16'h0, activeChDly[16 +: 16]}, 32'h8383);

    // R5: trigger only
    loadMode = 2'b10;
    writeBuf("R5", 6, 16'h5555);
    arm("R5");
    modMatch = 1; cyc("R5"); modMatch = 0;
    repeat (2) cyc("R5");
    chk("R5 still pending", {31'h0, loadPending}, 32'h1);
    trigEvent = 1; cyc("R5"); trigEvent = 0;
    chk("R5 copied", {16'h0, activePoDly[0 +: 16]}, 32'h5555);

    // R6: first of either
    loadMode = 2'b11;
    writeBuf("R6", 7, 16'h6161);
    arm("R6");
    cyc("R6");
    chk("R6 waiting", {31'h0, loadPending}, 32'h1);
    trigEvent = 1; cyc("R6"); trigEvent = 0;
    chk("R6 on trigger", {16'h0, activePoDly[16 +: 16]}, 32'h6161);
    writeBuf("R6", 7, 16'h6262);
    arm("R6");
    modMatch = 1; cyc("R6"); modMatch = 0;
    chk("R6 on match", {16'h0, activePoDly[16 +: 16]}, 32'h6262);

    // R10: disabling drops a pending transfer
    loadMode = 2'b01;
    writeBuf("R10", 0, 16'hA0A0);
    arm("R10");
    enable = 0; modMatch = 1; cyc("R10"); modMatch = 0;
    chk("R10 dropped", {31'h0, loadPending}, 32'h0);
    chk("R10 no copy", {16'h0, activeMod}, 32'h0BAD);
    enable = 1;

    // R11: events with nothing pending
    loadMode = 2'b11;
    modMatch = 1; trigEvent = 1;
    repeat (3) cyc("R11");
    idle();
    chk("R11 no copy", {16'h0, activeMod}, 32'h0BAD);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      enable    = ($urandom_range(19) != 0);
      armWr     = ($urandom_range(9) == 0);
      wrEn      = ($urandom_range(1) == 0);
      wrSel     = 4'($urandom_range(15));
      wrData    = 16'($urandom());
      modMatch  = ($urandom_range(9) == 0);
      trigEvent = ($urandom_range(9) == 0);
      if ($urandom_range(49) == 0) loadMode = 2'($urandom_range(3));
      cyc("R8 random");
    end
    idle();
    cyc("R8 random");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule